// File: doc/BRIEF.md
# Paged Serial EEPROM Write Slave

This block models the write side of a 256-byte two-wire serial EEPROM. It runs on a system clock and oversamples the SCL and SDA lines. It pulls SDA low through an open-drain enable. After START it compares the 7-bit device address and loads an 8-bit word address into a pointer. It then gathers data bytes into a 16-entry page buffer. Only the low four pointer bits advance, so a long burst wraps inside its page.

When STOP ends a transaction that carried at least one data byte, the page buffer is copied into the storage array during a timed busy interval of `WR_CYCLES` system clocks. During that interval the block ignores the bus. A host can therefore poll for completion by repeating START plus the write address until an acknowledge returns. A write-protect input is sampled once per transaction. When it is set at that point, the first data byte is refused and the transaction is dropped. A registered monitor read port lets the surrounding system observe the array contents.

Top module: `eew_write_slave`

## Requirements
- R1: The device answers with ACK only to the address byte `{4'b1010, dev_sel, 1'b0}`, where bit 0 is R/W. Any other address byte, including one with R/W = 1, gets NACK, and the bytes that follow are ignored until the next START.
- R2: The byte after an acknowledged device address is always acknowledged. It loads the 8-bit word pointer, and the first data byte is destined for that address.
- R3: Each acknowledged data byte advances only pointer bits [3:0], modulo 16, and leaves bits [7:4] unchanged. A burst longer than 16 bytes wraps to the start of the same page, and the later bytes replace the earlier ones.
- R4: Data bytes stay in the page buffer and do not reach the array before STOP. A START that arrives before STOP discards them. STOP then writes every buffered byte of the page, and no other array location changes.
- R5: For `WR_CYCLES` clocks after the committing STOP, SDA is never pulled low and a poll (START plus write address) gets NACK. Once that interval ends, a poll gets ACK.
- R6: `wp_i` is sampled on the SCL falling edge that closes the word-address ACK slot. If it is high there, the first data byte gets NACK, nothing is written, and no busy interval starts: an immediate poll is acknowledged.
- R7: A low `wp_i` at the sampling edge has no effect. Changes of `wp_i` at any other time also have no effect.
- R8: After power-up every array byte reads FFh.
- R9: A STOP that follows only the word address, with no data byte, starts no busy interval: an immediate poll is acknowledged and the array is unchanged.
- R10: `sda_oe` is only asserted from a detected SCL falling edge that closes a byte. It is released on the next SCL falling edge, or on START or STOP, and it is low in the cycle after every START.
- R11: `mon_data` returns the array byte at `mon_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| dev_sel | input | 3 | Strapped low bits of the device address |
| wp_i | input | 1 | Write-protect input |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| mon_addr | input | 8 | Monitor read address |
| mon_data | output | 8 | Array byte at mon_addr, one clock late |

## Verification
The write-protect strobe and the release of the word-address acknowledge happen on the same detected SCL falling edge. A sampling slip of even one edge would go unnoticed unless `wp_i` changes right around that point. The bench sets `wp_i` before the word address and inverts it right after that byte's acknowledge clock. It then judges the outcome by whether the first data byte is acknowledged, and by whether the page in the array changed after an immediate poll. Randomized transactions with random pages, offsets, lengths of up to 20 bytes and a random protect level repeat this against a reference model of the array.

// File: rtl/eew_pkg.sv
package eew_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_DATA,
    ST_COMMIT
  } wr_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eew_bus_sync.sv
module eew_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eew_page_ctrl.sv
module eew_page_ctrl
  import eew_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        dev_sel,
  input  logic              wp_i,
  output logic              sda_oe,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TMR_W = $clog2(WR_CYCLES + 1);

  wr_state_t         state;
  logic [7:0]        shreg;
  logic [3:0]        bitcnt;
  logic              ack_ph, wp_lat;
  logic [ADDR_W-1:0] ptr;
  logic [PAGE-1:0]   pvalid;
  logic [TMR_W-1:0]  tmr;
  logic [7:0]        pbuf [PAGE];
  logic              byte_end, pb_we;
  logic [PAGE_W-1:0] cidx;

  assign byte_end = scl_fall && !ack_ph && (bitcnt == 4'd8);
  assign pb_we    = (state == ST_DATA) && byte_end && !wp_lat;
  assign cidx     = tmr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[ptr[PAGE_W-1:0]] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      wp_lat <= 1'b0;
      ptr    <= '0;
      pvalid <= '0;
      tmr    <= '0;
      sda_oe <= 1'b0;
    end else if (state == ST_COMMIT) begin
      sda_oe <= 1'b0;
      if (tmr == TMR_W'(WR_CYCLES - 1)) begin
        state  <= ST_IDLE;
        pvalid <= '0;
        tmr    <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else if (start_det) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
      pvalid <= '0;
    end else if (stop_det) begin
      sda_oe <= 1'b0;
      ack_ph <= 1'b0;
      if (state == ST_DATA && |pvalid) begin
        state <= ST_COMMIT;
        tmr   <= '0;
      end else begin
        state  <= ST_IDLE;
        pvalid <= '0;
      end
    end else if (state != ST_IDLE) begin
      if (scl_rise && !ack_ph && bitcnt != 4'd8) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (scl_fall && ack_ph) begin
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
        bitcnt <= '0;
        if (state == ST_DATA && pvalid == '0) wp_lat <= wp_i;
      end else if (byte_end) begin
        unique case (state)
          ST_DEV: begin
            if (shreg == {DEV_TYPE, dev_sel, 1'b0}) begin
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
              state  <= ST_WORD;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_WORD: begin
            ptr    <= shreg[ADDR_W-1:0];
            sda_oe <= 1'b1;
            ack_ph <= 1'b1;
            state  <= ST_DATA;
          end
          ST_DATA: begin
            if (wp_lat) begin
              state <= ST_IDLE;
            end else begin
              sda_oe <= 1'b1;
              ack_ph <= 1'b1;
              pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
              ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy      = (state == ST_COMMIT);
  assign mem_we    = busy && (tmr < TMR_W'(PAGE)) && pvalid[cidx];
  assign mem_waddr = {ptr[ADDR_W-1:PAGE_W], cidx};
  assign mem_wdata = pbuf[cidx];
endmodule

// File: rtl/eew_array.sv
module eew_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eew_write_slave.sv
module eew_write_slave #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_sel,
  input  logic              wp_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] mon_addr,
  output logic [7:0]        mon_data
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0] mem_wdata;

  eew_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eew_page_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .dev_sel(dev_sel), .wp_i(wp_i), .sda_oe(sda_oe), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eew_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mon_addr), .rdata(mon_data)
  );
endmodule

// File: rtl/eew_write_slave_chk.sv
module eew_write_slave_chk (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic busy,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det
);
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  p_commit_on_stop_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  p_ack_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  p_ack_release_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  p_start_no_ack_r1: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);
endmodule

bind eew_write_slave eew_write_slave_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .busy(busy),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/eew_write_slave_tb_top.sv
`timescale 1ns/1ps
module eew_write_slave_tb_top;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic sda_oe;
  logic [7:0] mon_addr = '0, mon_data;
  logic sda_line;
  int checks = 0, fails = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] tx_data [32];

  assign sda_line = sda_h & ~sda_oe;

  always #5 clk = ~clk;

  eew_write_slave #(.WR_CYCLES(300)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_line),
    .dev_sel(STRAP), .wp_i(wp), .sda_oe(sda_oe),
    .mon_addr(mon_addr), .mon_data(mon_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; qwait(Q);
    sda_h = 1'b0; qwait(Q);
    scl_h = 1'b0; qwait(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; qwait(Q);
    scl_h = 1'b1; qwait(Q);
    sda_h = 1'b1; qwait(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; qwait(Q);
      scl_h = 1'b1; qwait(2*Q);
      scl_h = 1'b0; qwait(Q);
    end
    sda_h = 1'b1; qwait(Q);
    scl_h = 1'b1; qwait(Q);
    ack = !sda_line;
    qwait(Q);
    scl_h = 1'b0; qwait(Q);
  endtask

  task automatic poll(output bit ack);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    bus_stop();
  endtask

  task automatic mon_read(input int a, output logic [7:0] v);
    mon_addr = 8'(a);
    qwait(2);
    v = mon_data;
  endtask

  function automatic void apply_page(input int base, input int lo, input int n);
    int p = lo;
    for (int i = 0; i < n; i++) begin
      exp_mem[base*16 + p] = tx_data[i];
      p = (p + 1) % 16;
    end
  endfunction

  task automatic check_page(input int base, input string req);
    logic [7:0] v;
    for (int k = 0; k < 16; k++) begin
      mon_read(base*16 + k, v);
      check(v == exp_mem[base*16 + k], req, v, exp_mem[base*16 + k]);
    end
  endtask

  task automatic do_write(input int base, input int lo, input int n, input bit wpv);
    bit a;
    int polls;
    logic [7:0] v;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    check(a, "R1 address ack", a, 1);
    wp = wpv;
    send_byte({4'(base), 4'(lo)}, a);
    check(a, "R2 word address ack", a, 1);
    wp = !wpv;
    send_byte(tx_data[0], a);
    if (wpv) check(a == 1'b0, "R6 protected first byte", a, 0);
    else     check(a == 1'b1, "R7 wp change after strobe", a, 1);
    if (wpv) begin
      wp = 1'b0;
      bus_stop();
      poll(a);
      check(a, "R6 no write cycle", a, 1);
      check_page(base, "R6 page unchanged");
      return;
    end
    for (int i = 1; i < n; i++) begin
      send_byte(tx_data[i], a);
      check(a, "R3 data ack", a, 1);
    end
    wp = 1'b0;
    mon_read(base*16 + lo, v);
    check(v == exp_mem[base*16 + lo], "R4 held until STOP", v, exp_mem[base*16 + lo]);
    bus_stop();
    poll(a);
    check(!a, "R5 busy poll nack", a, 0);
    polls = 0;
    while (!a && polls < 20) begin
      poll(a);
      polls++;
    end
    check(a, "R5 poll ack after cycle", a, 1);
    apply_page(base, lo, n);
    check_page(base, "R3 R4 page content");
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    qwait(5);
    rst = 1'b0;
    qwait(5);
    check(sda_oe == 1'b0, "R10 reset sda released", sda_oe, 0);
    for (int i = 0; i < 6; i++) begin
      int ad = $urandom_range(0, 255);
      mon_read(ad, v);
      check(v == 8'hFF, "R8 erased byte", v, 8'hFF);
    end
    mon_read(8'h3C, v);
    check(v == exp_mem[8'h3C], "R11 monitor read", v, exp_mem[8'h3C]);

    // R1: wrong strap, then further bytes ignored
    bus_start();
    send_byte({4'b1010, ~STRAP, 1'b0}, a);
    check(!a, "R1 strap mismatch nack", a, 0);
    send_byte(8'h20, a);
    check(!a, "R1 ignored after mismatch", a, 0);
    send_byte(8'h55, a);
    check(!a, "R1 ignored data", a, 0);
    bus_stop();
    // R1: read direction refused
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a);
    check(!a, "R1 read bit nack", a, 0);
    bus_stop();
    check_page(2, "R1 page unchanged");

    // R9: stop after word address only
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    send_byte(8'h47, a);
    check(a, "R9 word ack", a, 1);
    bus_stop();
    poll(a);
    check(a, "R9 no write cycle", a, 1);
    check_page(4, "R9 page unchanged");

    // R3: wrap past page end, 18 bytes from offset 14
    for (int i = 0; i < 18; i++) tx_data[i] = 8'(8'h80 + i);
    do_write(7, 14, 18, 1'b0);
    // R6: protected write
    for (int i = 0; i < 4; i++) tx_data[i] = 8'(8'h11 * i);
    do_write(9, 3, 4, 1'b1);
    // short directed write, single byte
    tx_data[0] = 8'h5A;
    do_write(0, 0, 1, 1'b0);

    for (int t = 0; t < 8; t++) begin
      int base = $urandom_range(0, 15);
      int lo = $urandom_range(0, 15);
      int n = $urandom_range(1, 20);
      bit wpv = ($urandom_range(0, 4) == 0);
      for (int i = 0; i < n; i++) tx_data[i] = 8'($urandom);
      do_write(base, lo, n, wpv);
    end

    for (int i = 0; i < 256; i++) begin
      mon_read(i, v);
      check(v == exp_mem[i], "R4 array sweep", v, exp_mem[i]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule